// File: doc/BRIEF.md
# Video Framebuffer Write Snooper with Posted Cache

This block sits beside a 68000-style CPU bus and watches every bus cycle. When the CPU writes into the primary video framebuffer, the written bytes are captured into a small first-in first-out cache. They are then copied one byte at a time into a local 32K x 8 video SRAM. The display side still reads that SRAM for output, so the cache must wait for the display's permission before each copy. The block itself never drives the CPU bus.

The framebuffer does not sit at a fixed address. It starts 0x5900 bytes below the top of installed RAM, and a 3-bit RAM-size code selects that top. The framebuffer holds 512 x 342 pixels at one bit per pixel, which is 21888 bytes. Each captured byte is stored with its offset from the framebuffer base, and that offset is the address used in video SRAM.

Top module: `fb_snoop_cache`

## Requirements
- R1: The top of RAM is (ram_code + 1) x 0x80000 bytes, and the framebuffer base is that top minus 0x5900. For example, code 000 gives a top of 0x080000 and a base of 0x07A700, and code 111 gives a top of 0x400000.
- R2: A CPU write is captured only when its byte address (cpu_addr followed by a 0 bit) is at or above the base and below base + 21888.
- R3: RAM-size codes 010, 101 and 110 are not valid memory sizes. With any of these codes, no write is captured.
- R4: Bus cycles with cpu_rw = 1 (reads) are never captured.
- R5: When both cpu_uds_n and cpu_lds_n are low, the write becomes two cache bytes. Bits 15:8 go to the even offset and bits 7:0 go to the offset + 1. When only one strobe is low, only that byte is stored. When neither strobe is low, nothing is stored.
- R6: The video SRAM address of a byte is its CPU byte address minus the base, truncated to 15 bits.
- R7: Each bus cycle (one interval with cpu_as_n low) is captured at most once, however long cpu_as_n stays low.
- R8: Bytes are written to video SRAM in the order in which they were captured.
- R9: vram_req is high exactly while the cache holds at least one byte. A byte is written (vram_we high for one cycle) only in the cycle after a cycle in which vram_gnt was high. While vram_gnt stays low, no write occurs and no cached byte is lost.
- R10: When the cache lacks room for a write's bytes, the write is held while cpu_as_n stays low and is captured once enough slots have drained. If cpu_as_n rises before that happens, the write is dropped.
- R11: After reset, the cache is empty and both vram_req and vram_we are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | ADDR_W-1 | CPU word address (byte address bits ADDR_W-1 down to 1) |
| cpu_data | input | 16 | CPU write data |
| cpu_uds_n | input | 1 | Upper (even) byte strobe, active low |
| cpu_lds_n | input | 1 | Lower (odd) byte strobe, active low |
| cpu_as_n | input | 1 | Address strobe, active low |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| ram_code | input | 3 | Installed RAM size code |
| vram_gnt | input | 1 | Display side permits one SRAM write this cycle |
| vram_req | output | 1 | Cache holds data waiting to be written |
| vram_addr | output | 15 | Video SRAM byte address |
| vram_data | output | 8 | Video SRAM write data |
| vram_we | output | 1 | Video SRAM write enable, active high |

## Verification
The bench builds the block with a 24-bit address and a four-byte cache. For every one of the eight RAM-size codes, it sweeps addresses just below, at, inside and just past the framebuffer window, cycling through all strobe patterns and read cycles. A cache this small fills after only two full-word writes, so the held write, the dropped write and the grant-starved drain are all reachable in a few cycles. Every expected SRAM address is worked out arithmetically from the code and the byte address.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

    localparam int VA_W     = 15;
    localparam int BYTE_W   = 8;
    localparam int FB_BYTES = 21888;
    localparam int FB_GAP   = 'h5900;
    localparam int RAM_STEP = 'h80000;

    typedef struct packed {
        logic [VA_W-1:0]   addr;
        logic [BYTE_W-1:0] data;
    } fbs_entry_t;

    typedef enum logic [1:0] {
        PUSH_NONE = 2'd0,
        PUSH_ONE  = 2'd1,
        PUSH_TWO  = 2'd2
    } fbs_push_t;

    function automatic logic fbs_code_valid(input logic [2:0] code);
        case (code)
            3'b010, 3'b101, 3'b110: return 1'b0;
            default:                return 1'b1;
        endcase
    endfunction

    function automatic logic [31:0] fbs_base(input logic [2:0] code);
        return (32'(code) + 32'd1) * 32'(RAM_STEP) - 32'(FB_GAP);
    endfunction

endpackage

// File: rtl/fbs_window.sv
module fbs_window
    import fbs_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic [2:0]        ram_code,
    input  logic [ADDR_W-1:0] byte_addr,
    output logic              hit,
    output logic [VA_W-1:0]   offset
);
    logic [31:0] base;
    logic [31:0] addr32;
    logic [31:0] diff;

    always_comb begin
        base   = fbs_base(ram_code);
        addr32 = 32'(byte_addr);
        diff   = addr32 - base;
        hit    = fbs_code_valid(ram_code) && (addr32 >= base)
                 && (diff < 32'(FB_BYTES));
        offset = diff[VA_W-1:0];
    end
endmodule

// File: rtl/fbs_capture.sv
module fbs_capture
    import fbs_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             as_n,
    input  logic             rw,
    input  logic             uds_n,
    input  logic             lds_n,
    input  logic [15:0]      data,
    input  logic             hit,
    input  logic [VA_W-1:0]  offset,
    input  logic [CNT_W-1:0] free,
    output fbs_push_t        push_n,
    output fbs_entry_t       ent0,
    output fbs_entry_t       ent1
);
    logic            taken;
    logic [1:0]      needed;
    logic            accept;
    logic [VA_W-1:0] odd_off;

    always_comb begin
        needed  = 2'(!uds_n) + 2'(!lds_n);
        accept  = !as_n && !rw && hit && !taken && (needed != 2'd0)
                  && (32'(free) >= 32'(needed));
        odd_off = {offset[VA_W-1:1], 1'b1};
        push_n  = accept ? fbs_push_t'(needed) : PUSH_NONE;
        if (!uds_n) begin
            ent0 = '{addr: {offset[VA_W-1:1], 1'b0}, data: data[15:8]};
        end else begin
            ent0 = '{addr: odd_off, data: data[7:0]};
        end
        ent1 = '{addr: odd_off, data: data[7:0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            taken <= 1'b0;
        end else if (as_n) begin
            taken <= 1'b0;
        end else if (accept) begin
            taken <= 1'b1;
        end
    end

    AST_ONE_PER_BUS_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (push_n != PUSH_NONE) |=> (push_n == PUSH_NONE)); // R7
endmodule

// File: rtl/fbs_fifo.sv
module fbs_fifo
    import fbs_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  fbs_push_t        push_n,
    input  fbs_entry_t       ent0,
    input  fbs_entry_t       ent1,
    input  logic             pop,
    output fbs_entry_t       head,
    output logic             empty,
    output logic [CNT_W-1:0] free
);
    fbs_entry_t       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;

    always_comb begin
        head  = mem[rd_ptr];
        empty = (count == '0);
        free  = CNT_W'(DEPTH) - count;
    end

    always_ff @(posedge clk) begin
        if (push_n != PUSH_NONE) begin
            mem[wr_ptr] <= ent0;
        end
        if (push_n == PUSH_TWO) begin
            mem[PTR_W'(wr_ptr + 1'b1)] <= ent1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + PTR_W'(push_n);
            rd_ptr <= rd_ptr + PTR_W'(pop);
            count  <= count + CNT_W'(push_n) - CNT_W'(pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        32'(push_n) <= 32'(free)); // R10
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty); // R9
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        32'(count) <= 32'(DEPTH)); // R10
endmodule

// File: rtl/fbs_drain.sv
module fbs_drain
    import fbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              gnt,
    input  logic              empty,
    input  fbs_entry_t        head,
    output logic              pop,
    output logic              vram_req,
    output logic              vram_we,
    output logic [VA_W-1:0]   vram_addr,
    output logic [BYTE_W-1:0] vram_data
);
    always_comb begin
        vram_req = !empty;
        pop      = gnt && !empty;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vram_we   <= 1'b0;
            vram_addr <= '0;
            vram_data <= '0;
        end else begin
            vram_we <= pop;
            if (pop) begin
                vram_addr <= head.addr;
                vram_data <= head.data;
            end
        end
    end

    AST_WE_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
        vram_we |-> $past(gnt)); // R9
    AST_REQ_KEPT_UNGRANTED: assert property (@(posedge clk) disable iff (rst)
        (vram_req && !gnt) |=> vram_req); // R9
endmodule

// File: rtl/fb_snoop_cache.sv
module fb_snoop_cache
    import fbs_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DEPTH  = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-2:0] cpu_addr,
    input  logic [15:0]       cpu_data,
    input  logic              cpu_uds_n,
    input  logic              cpu_lds_n,
    input  logic              cpu_as_n,
    input  logic              cpu_rw,
    input  logic [2:0]        ram_code,
    input  logic              vram_gnt,
    output logic              vram_req,
    output logic [14:0]       vram_addr,
    output logic [7:0]        vram_data,
    output logic              vram_we
);
    logic             hit;
    logic [VA_W-1:0]  offset;
    fbs_push_t        push_n;
    fbs_entry_t       ent0;
    fbs_entry_t       ent1;
    fbs_entry_t       head;
    logic             empty;
    logic [CNT_W-1:0] free;
    logic             pop;

    fbs_window #(.ADDR_W(ADDR_W)) u_window (
        .ram_code  (ram_code),
        .byte_addr ({cpu_addr, 1'b0}),
        .hit       (hit),
        .offset    (offset)
    );

    fbs_capture #(.CNT_W(CNT_W)) u_capture (
        .clk    (clk),
        .rst    (rst),
        .as_n   (cpu_as_n),
        .rw     (cpu_rw),
        .uds_n  (cpu_uds_n),
        .lds_n  (cpu_lds_n),
        .data   (cpu_data),
        .hit    (hit),
        .offset (offset),
        .free   (free),
        .push_n (push_n),
        .ent0   (ent0),
        .ent1   (ent1)
    );

    fbs_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk    (clk),
        .rst    (rst),
        .push_n (push_n),
        .ent0   (ent0),
        .ent1   (ent1),
        .pop    (pop),
        .head   (head),
        .empty  (empty),
        .free   (free)
    );

    fbs_drain u_drain (
        .clk       (clk),
        .rst       (rst),
        .gnt       (vram_gnt),
        .empty     (empty),
        .head      (head),
        .pop       (pop),
        .vram_req  (vram_req),
        .vram_we   (vram_we),
        .vram_addr (vram_addr),
        .vram_data (vram_data)
    );

    AST_READ_IGNORED: assert property (@(posedge clk) disable iff (rst)
        cpu_rw |-> (push_n == PUSH_NONE)); // R4
    AST_BAD_CODE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !fbs_code_valid(ram_code) |-> (push_n == PUSH_NONE)); // R3
endmodule

// File: tb/fb_snoop_cache_test.sv
`timescale 1ns/1ps
module fb_snoop_cache_test;
    localparam int ADDR_W = 24;
    localparam int DEPTH  = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-2:0] cpu_addr = '0;
    logic [15:0]       cpu_data = '0;
    logic              cpu_uds_n = 1'b1;
    logic              cpu_lds_n = 1'b1;
    logic              cpu_as_n = 1'b1;
    logic              cpu_rw = 1'b1;
    logic [2:0]        ram_code = 3'b000;
    logic              vram_gnt = 1'b0;
    logic              vram_req;
    logic [14:0]       vram_addr;
    logic [7:0]        vram_data;
    logic              vram_we;

    int checks = 0;
    int fails  = 0;
    logic gnt_d = 1'b0;
    logic [22:0] exp_q [$];

    fb_snoop_cache #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_uds_n(cpu_uds_n), .cpu_lds_n(cpu_lds_n), .cpu_as_n(cpu_as_n),
        .cpu_rw(cpu_rw), .ram_code(ram_code), .vram_gnt(vram_gnt),
        .vram_req(vram_req), .vram_addr(vram_addr), .vram_data(vram_data),
        .vram_we(vram_we)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) gnt_d <= vram_gnt;

    always @(negedge clk) begin
        if (!rst && vram_we) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R2 R3 R4 R7 unexpected write actual=%h/%h expected none",
                         vram_addr, vram_data);
            end else begin
                logic [22:0] e;
                e = exp_q.pop_front();
                if ({vram_addr, vram_data} !== e) begin
                    fails++;
                    $display("FAIL R1 R5 R6 R8 write actual=%h/%h expected=%h/%h",
                             vram_addr, vram_data, e[22:8], e[7:0]);
                end
            end
            checks++;
            if (!gnt_d) begin
                fails++;
                $display("FAIL R9 write without grant actual gnt=%b expected 1", gnt_d);
            end
        end
    end

    function automatic bit code_ok(input int c);
        return !(c == 2 || c == 5 || c == 6);
    endfunction

    function automatic int base_of(input int c);
        return (c + 1) * 524288 - 22784;
    endfunction

    task automatic expect_write(input int c, input int off, input logic [15:0] d,
                                input logic u_n, input logic l_n, input logic rw);
        if (!rw && code_ok(c) && off >= 0 && off < 21888) begin
            if (!u_n) exp_q.push_back({15'(off), d[15:8]});
            if (!l_n) exp_q.push_back({15'(off + 1), d[7:0]});
        end
    endtask

    task automatic bus_cycle(input int baddr, input logic [15:0] d,
                             input logic u_n, input logic l_n, input logic rw,
                             input int hold);
        @(negedge clk);
        cpu_addr  = (ADDR_W-1)'(baddr >> 1);
        cpu_data  = d;
        cpu_uds_n = u_n;
        cpu_lds_n = l_n;
        cpu_rw    = rw;
        cpu_as_n  = 1'b0;
        repeat (hold) @(negedge clk);
        cpu_as_n  = 1'b1;
        cpu_uds_n = 1'b1;
        cpu_lds_n = 1'b1;
        cpu_rw    = 1'b1;
    endtask

    task automatic check_bit(input string req, input logic act, input logic expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, expv);
        end
    endtask

    task automatic check_drained(input string req);
        repeat (12) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL %s pending writes actual=%0d expected=0", req, exp_q.size());
        end
        check_bit(req, vram_req, 1'b0);
    endtask

    bit done = 0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int offs [6] = '{-2, 0, 2, 256, 21886, 21888};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        check_bit("R11 req after reset", vram_req, 1'b0);
        check_bit("R11 we after reset", vram_we, 1'b0);

        // R1 R2 R3 R4 R5 R6: sweep every code, window edges, strobe patterns
        vram_gnt = 1'b1;
        for (int c = 0; c < 8; c++) begin
            ram_code = 3'(c);
            for (int i = 0; i < 6; i++) begin
                logic [15:0] d;
                logic u_n, l_n;
                d   = 16'((c << 12) ^ (i * 16'h1357) ^ 16'h5AA5);
                u_n = (i % 3) == 2;
                l_n = (i % 3) == 1;
                expect_write(c, offs[i], d, u_n, l_n, 1'b0);
                bus_cycle(base_of(c) + offs[i], d, u_n, l_n, 1'b0, 2);
                repeat (4) @(negedge clk);
            end
            // R4: read inside window is ignored
            bus_cycle(base_of(c) + 64, 16'hDEAD, 1'b0, 1'b0, 1'b1, 2);
            // R5: write with no strobe stores nothing
            bus_cycle(base_of(c) + 66, 16'hBEEF, 1'b1, 1'b1, 1'b0, 2);
            check_drained("R1 R2 R3 R4 R5 R6 sweep");
        end

        // R7: long bus cycle captured once
        ram_code = 3'b011;
        expect_write(3, 500, 16'hA1B2, 1'b0, 1'b0, 1'b0);
        bus_cycle(base_of(3) + 500, 16'hA1B2, 1'b0, 1'b0, 1'b0, 12);
        check_drained("R7 single capture");

        // R9 R10 R8: fill without grant, drop one, hold one
        ram_code = 3'b000;
        vram_gnt = 1'b0;
        expect_write(0, 16, 16'h1122, 1'b0, 1'b0, 1'b0);
        bus_cycle(base_of(0) + 16, 16'h1122, 1'b0, 1'b0, 1'b0, 2);
        expect_write(0, 32, 16'h3344, 1'b0, 1'b0, 1'b0);
        bus_cycle(base_of(0) + 32, 16'h3344, 1'b0, 1'b0, 1'b0, 2);
        repeat (3) @(negedge clk);
        check_bit("R9 req while ungranted", vram_req, 1'b1);
        check_bit("R9 no write while ungranted", vram_we, 1'b0);
        // R10: cycle ends while full, so it is dropped
        bus_cycle(base_of(0) + 48, 16'h5566, 1'b0, 1'b0, 1'b0, 3);
        // R10: cycle held until grant drains room
        expect_write(0, 80, 16'h7788, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        cpu_addr  = (ADDR_W-1)'((base_of(0) + 80) >> 1);
        cpu_data  = 16'h7788;
        cpu_uds_n = 1'b0;
        cpu_lds_n = 1'b0;
        cpu_rw    = 1'b0;
        cpu_as_n  = 1'b0;
        repeat (3) @(negedge clk);
        check_bit("R9 req still high before grant", vram_req, 1'b1);
        vram_gnt = 1'b1;
        repeat (6) @(negedge clk);
        cpu_as_n  = 1'b1;
        cpu_uds_n = 1'b1;
        cpu_lds_n = 1'b1;
        cpu_rw    = 1'b1;
        check_drained("R8 R10 held write");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule